// File: doc/BRIEF.md
# Priority Window Background Compositor

This block lays up to three rectangular background windows over a display made of character cells, and merges them with the character dots into the final colour and blanking signals sent to the monitor. For every dot it receives the cell row and column the beam is in, a flag saying whether a character dot is lit, and that dot's colour. From these and the stored window settings it decides which window, if any, owns the cell. It then produces the RGB colour, a fast-blank signal that tells the video amplifier to switch to on-screen data, and a half-tone signal that dims the picture behind a window to give a see-through look.

Each window has a row range, a column range, an enable and a 3-bit colour. The windows have a fixed precedence, and window 0 is the strongest. A window whose start lies past its end on either axis never shows. A character dot always wins over window colour. A mode input chooses whether fast-blank covers windows as well as characters, or characters only.

Top module: `bgwin_compositor`

## Requirements
- R1: While `rst_n` is low, `rgb_out`, `fblank_out` and `htone_out` are all 0.
- R2: When `disp_en` is 0 at a clock edge, all three outputs are 0 after that edge, whatever the other inputs are.
- R3: Outputs are registered. The values seen after a rising edge depend only on the inputs sampled at that edge, and they do not change between edges.
- R4: Window k (k = 0..NWIN-1, with its fields in slice k of each packed window port) covers a cell when `win_en[k]` is 1, row_lo ≤ row ≤ row_hi and col_lo ≤ col ≤ col_hi. Both bounds are inclusive. A window whose enable bit is 0 covers nothing.
- R5: A window whose row start is greater than its row end, or whose column start is greater than its column end, covers no cell.
- R6: Where several windows cover a cell, the window with the lowest index supplies the window colour.
- R7: `rgb_out` is the bitwise OR of the character colour and the window colour. The character colour is `chr_rgb` when `chr_on` is 1 and 0 otherwise. The window colour is the winning window's colour when a window covers the cell and `chr_on` is 0, and 0 otherwise.
- R8: `htone_out` is 1 exactly when a window covers the cell and `chr_on` is 0.
- R9: With `fb_mode` = 0, `fblank_out` is 1 when `chr_on` is 1 or a window covers the cell. With `fb_mode` = 1, `fblank_out` equals `chr_on`.
- R10: `fb_mode` has no effect on `rgb_out` or `htone_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| disp_en | input | 1 | Global display enable |
| cell_row | input | ROW_W (4) | Character row of the current dot |
| cell_col | input | COL_W (5) | Character column of the current dot |
| chr_on | input | 1 | A character dot is lit at this position |
| chr_rgb | input | CLR_W (3) | Colour of the character dot |
| fb_mode | input | 1 | 0: fast-blank covers characters and windows; 1: characters only |
| win_en | input | NWIN (3) | Per-window enable, bit k for window k |
| win_row_lo | input | NWIN*ROW_W (12) | Per-window first row |
| win_row_hi | input | NWIN*ROW_W (12) | Per-window last row |
| win_col_lo | input | NWIN*COL_W (15) | Per-window first column |
| win_col_hi | input | NWIN*COL_W (15) | Per-window last column |
| win_clr | input | NWIN*CLR_W (9) | Per-window RGB colour |
| rgb_out | output | CLR_W (3) | Composited RGB |
| fblank_out | output | 1 | Fast-blank |
| htone_out | output | 1 | Half-tone, asserted on uncovered window area |

## Verification
A wrong coverage decision or precedence pick shows up as a wrong colour or a missing half-tone on the very next dot after the cell is presented. The bench places dots on window edges, in overlap zones, and on inverted and disabled windows so that such an error appears within one cycle. A fault in the suppression of the window colour under a character shows up as extra RGB bits and a set half-tone on a lit dot. A fault in the blanking mode shows up as fast-blank on bare window area. Because every output is a single register stage away from its inputs, no error can stay hidden for longer than one cycle.

// File: rtl/bgwin_pkg.sv
package bgwin_pkg;

    // default geometry of the window set
    localparam int DEF_NWIN  = 3;
    localparam int DEF_ROW_W = 4;
    localparam int DEF_COL_W = 5;
    localparam int DEF_CLR_W = 3;

    // coverage of the fast-blank output
    typedef enum logic {
        FB_DOT_OR_WIN = 1'b0,
        FB_DOT_ONLY   = 1'b1
    } fb_mode_e;

endpackage

// File: rtl/bgwin_hit.sv
// Decides whether one window covers the current cell (inclusive bounds).
module bgwin_hit #(
    parameter int ROW_W = 4,
    parameter int COL_W = 5
) (
    input  logic [ROW_W-1:0] cell_row,
    input  logic [COL_W-1:0] cell_col,
    input  logic [ROW_W-1:0] row_lo,
    input  logic [ROW_W-1:0] row_hi,
    input  logic [COL_W-1:0] col_lo,
    input  logic [COL_W-1:0] col_hi,
    input  logic             en,
    output logic             hit
);

    logic row_in;
    logic col_in;

    // an inverted range has no value that meets both compares
    always_comb begin
        row_in = (cell_row >= row_lo) && (cell_row <= row_hi);
        col_in = (cell_col >= col_lo) && (cell_col <= col_hi);
        hit    = en && row_in && col_in;
    end

endmodule

// File: rtl/bgwin_prio.sv
// Fixed-precedence pick: lowest index wins.
module bgwin_prio #(
    parameter int NWIN  = 3,
    parameter int CLR_W = 3
) (
    input  logic [NWIN-1:0]       hit,
    input  logic [NWIN*CLR_W-1:0] clr,
    output logic [NWIN-1:0]       sel,
    output logic                  any,
    output logic [CLR_W-1:0]      clr_out
);

    logic taken;

    always_comb begin
        sel     = '0;
        clr_out = '0;
        taken   = 1'b0;
        for (int i = 0; i < NWIN; i++) begin
            if (hit[i] && !taken) begin
                sel[i]  = 1'b1;
                clr_out = clr[i*CLR_W +: CLR_W];
                taken   = 1'b1;
            end
        end
    end

    assign any = taken;

endmodule

// File: rtl/bgwin_compositor.sv
module bgwin_compositor
    import bgwin_pkg::*;
#(
    parameter int NWIN  = DEF_NWIN,
    parameter int ROW_W = DEF_ROW_W,
    parameter int COL_W = DEF_COL_W,
    parameter int CLR_W = DEF_CLR_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  disp_en,
    input  logic [ROW_W-1:0]      cell_row,
    input  logic [COL_W-1:0]      cell_col,
    input  logic                  chr_on,
    input  logic [CLR_W-1:0]      chr_rgb,
    input  logic                  fb_mode,
    input  logic [NWIN-1:0]       win_en,
    input  logic [NWIN*ROW_W-1:0] win_row_lo,
    input  logic [NWIN*ROW_W-1:0] win_row_hi,
    input  logic [NWIN*COL_W-1:0] win_col_lo,
    input  logic [NWIN*COL_W-1:0] win_col_hi,
    input  logic [NWIN*CLR_W-1:0] win_clr,
    output logic [CLR_W-1:0]      rgb_out,
    output logic                  fblank_out,
    output logic                  htone_out
);

    typedef struct packed {
        logic [CLR_W-1:0] rgb;
        logic             fb;
        logic             ht;
    } pix_t;

    logic [NWIN-1:0]  win_hit;
    logic [NWIN-1:0]  win_sel;
    logic             win_any;
    logic [CLR_W-1:0] win_pick;
    logic [CLR_W-1:0] dot_rgb;
    logic [CLR_W-1:0] bg_rgb;
    fb_mode_e         mode;
    pix_t             pix_d;
    pix_t             pix_q;

    // one coverage test per window
    for (genvar g = 0; g < NWIN; g++) begin : g_win
        bgwin_hit #(
            .ROW_W (ROW_W),
            .COL_W (COL_W)
        ) u_hit (
            .cell_row (cell_row),
            .cell_col (cell_col),
            .row_lo   (win_row_lo[g*ROW_W +: ROW_W]),
            .row_hi   (win_row_hi[g*ROW_W +: ROW_W]),
            .col_lo   (win_col_lo[g*COL_W +: COL_W]),
            .col_hi   (win_col_hi[g*COL_W +: COL_W]),
            .en       (win_en[g]),
            .hit      (win_hit[g])
        );
    end

    bgwin_prio #(
        .NWIN  (NWIN),
        .CLR_W (CLR_W)
    ) u_prio (
        .hit     (win_hit),
        .clr     (win_clr),
        .sel     (win_sel),
        .any     (win_any),
        .clr_out (win_pick)
    );

    assign mode = fb_mode_e'(fb_mode);

    // next output value
    always_comb begin
        pix_d   = '0;
        dot_rgb = chr_on ? chr_rgb : '0;
        bg_rgb  = (win_any && !chr_on) ? win_pick : '0;
        if (disp_en) begin
            pix_d.rgb = dot_rgb | bg_rgb;
            pix_d.ht  = win_any && !chr_on;
            unique case (mode)
                FB_DOT_ONLY:   pix_d.fb = chr_on;
                FB_DOT_OR_WIN: pix_d.fb = chr_on || win_any;
                default:       pix_d.fb = chr_on;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_q <= '0;
        end else begin
            pix_q <= pix_d;
        end
    end

    assign rgb_out    = pix_q.rgb;
    assign fblank_out = pix_q.fb;
    assign htone_out  = pix_q.ht;

endmodule

// File: rtl/bgwin_compositor_chk.sv
module bgwin_compositor_chk #(
    parameter int NWIN  = 3,
    parameter int CLR_W = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  disp_en,
    input logic                  chr_on,
    input logic [CLR_W-1:0]      chr_rgb,
    input logic                  fb_mode,
    input logic [NWIN*CLR_W-1:0] win_clr,
    input logic [NWIN-1:0]       win_sel,
    input logic [CLR_W-1:0]      rgb_out,
    input logic                  fblank_out,
    input logic                  htone_out
);

    // R1
    reset_dark_chk: assert property (@(posedge clk)
        !rst_n |-> (rgb_out == '0) && !fblank_out && !htone_out);

    // R2
    display_off_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !disp_en) |=> (rgb_out == '0) && !fblank_out && !htone_out);

    // R6
    single_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win_sel));

    // R6
    top_window_colour_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && disp_en && !chr_on && win_sel[0])
            |=> rgb_out == $past(win_clr[CLR_W-1:0]));

    // R7
    dot_colour_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && disp_en && chr_on) |=> rgb_out == $past(chr_rgb));

    // R8
    no_tone_on_dot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && disp_en && chr_on) |=> !htone_out);

    // R9
    blank_dot_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && disp_en && fb_mode) |=> fblank_out == $past(chr_on));

    // R9
    blank_on_dot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && disp_en && chr_on) |=> fblank_out);

endmodule

bind bgwin_compositor bgwin_compositor_chk #(
    .NWIN  (NWIN),
    .CLR_W (CLR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .disp_en    (disp_en),
    .chr_on     (chr_on),
    .chr_rgb    (chr_rgb),
    .fb_mode    (fb_mode),
    .win_clr    (win_clr),
    .win_sel    (win_sel),
    .rgb_out    (rgb_out),
    .fblank_out (fblank_out),
    .htone_out  (htone_out)
);

// File: tb/bgwin_compositor_test.sv
module bgwin_compositor_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        disp_en = 1'b0;
    logic [3:0]  cell_row = '0;
    logic [4:0]  cell_col = '0;
    logic        chr_on = 1'b0;
    logic [2:0]  chr_rgb = '0;
    logic        fb_mode = 1'b0;
    logic [2:0]  win_en = '0;
    logic [11:0] win_row_lo = '0;
    logic [11:0] win_row_hi = '0;
    logic [14:0] win_col_lo = '0;
    logic [14:0] win_col_hi = '0;
    logic [8:0]  win_clr = '0;
    logic [2:0]  rgb_out;
    logic        fblank_out;
    logic        htone_out;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    bgwin_compositor uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .disp_en    (disp_en),
        .cell_row   (cell_row),
        .cell_col   (cell_col),
        .chr_on     (chr_on),
        .chr_rgb    (chr_rgb),
        .fb_mode    (fb_mode),
        .win_en     (win_en),
        .win_row_lo (win_row_lo),
        .win_row_hi (win_row_hi),
        .win_col_lo (win_col_lo),
        .win_col_hi (win_col_hi),
        .win_clr    (win_clr),
        .rgb_out    (rgb_out),
        .fblank_out (fblank_out),
        .htone_out  (htone_out)
    );

    // vector: row(4) col(5) dot(1) dot_rgb(3) mode(1) | exp rgb(3) fb(1) ht(1)
    localparam int NVEC = 13;
    localparam logic [18:0] VEC [NVEC] = '{
        {4'd3, 5'd9,  1'b0, 3'd0, 1'b0, 3'b001, 1'b1, 1'b1}, // R6 overlap w0/w1
        {4'd3, 5'd11, 1'b0, 3'd0, 1'b0, 3'b010, 1'b1, 1'b1}, // R4 w1 only
        {4'd2, 5'd5,  1'b0, 3'd0, 1'b0, 3'b001, 1'b1, 1'b1}, // R4 low corner
        {4'd4, 5'd10, 1'b0, 3'd0, 1'b0, 3'b001, 1'b1, 1'b1}, // R4 high corner
        {4'd1, 5'd5,  1'b0, 3'd0, 1'b0, 3'b000, 1'b0, 1'b0}, // R4 one row above
        {4'd6, 5'd12, 1'b0, 3'd0, 1'b0, 3'b010, 1'b1, 1'b1}, // R6 overlap w1/w2
        {4'd7, 5'd16, 1'b0, 3'd0, 1'b0, 3'b110, 1'b1, 1'b1}, // R8 w2 only
        {4'd7, 5'd21, 1'b0, 3'd0, 1'b0, 3'b000, 1'b0, 1'b0}, // R4 outside
        {4'd3, 5'd9,  1'b1, 3'd5, 1'b0, 3'b101, 1'b1, 1'b0}, // R7 dot over window
        {4'd3, 5'd9,  1'b0, 3'd0, 1'b1, 3'b001, 1'b0, 1'b1}, // R9 R10 window, dot-only blank
        {4'd3, 5'd9,  1'b1, 3'd3, 1'b1, 3'b011, 1'b1, 1'b0}, // R9 dot, dot-only blank
        {4'd1, 5'd1,  1'b1, 3'd7, 1'b1, 3'b111, 1'b1, 1'b0}, // R7 dot outside windows
        {4'd1, 5'd1,  1'b0, 3'd7, 1'b0, 3'b000, 1'b0, 1'b0}  // R7 unlit dot colour masked
    };

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual={rgb,fb,ht}=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic logic [4:0] outs();
        return {rgb_out, fblank_out, htone_out};
    endfunction

    task automatic drive(input logic [3:0] r, input logic [4:0] c, input logic d,
                         input logic [2:0] drgb, input logic m);
        cell_row = r;
        cell_col = c;
        chr_on   = d;
        chr_rgb  = drgb;
        fb_mode  = m;
    endtask

    // w0: rows 2-4 cols 5-10 colour 001
    // w1: rows 3-6 cols 8-15 colour 010
    // w2: rows 5-8 cols 12-20 colour 110
    task automatic base_windows();
        win_en     = 3'b111;
        win_row_lo = {4'd5, 4'd3, 4'd2};
        win_row_hi = {4'd8, 4'd6, 4'd4};
        win_col_lo = {5'd12, 5'd8, 5'd5};
        win_col_hi = {5'd20, 5'd15, 5'd10};
        win_clr    = {3'b110, 3'b010, 3'b001};
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        base_windows();
        disp_en = 1'b1;
        drive(4'd3, 5'd9, 1'b1, 3'd7, 1'b0);
        repeat (3) @(negedge clk);
        // R1: inputs would light every output, reset holds them low
        check("R1 reset", outs(), 5'b000_0_0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            drive(VEC[i][18:15], VEC[i][14:10], VEC[i][9], VEC[i][8:6], VEC[i][5]);
            @(negedge clk);
            check($sformatf("R4/R6/R7/R8/R9/R10 vector %0d", i), outs(), VEC[i][4:0]);
        end

        // R2: display off blanks a lit dot inside a window
        @(negedge clk);
        drive(4'd3, 5'd9, 1'b1, 3'd5, 1'b0);
        disp_en = 1'b0;
        @(negedge clk);
        check("R2 display off", outs(), 5'b000_0_0);

        // R3: new inputs do not reach the outputs before the edge
        disp_en = 1'b1;
        drive(4'd7, 5'd16, 1'b0, 3'd0, 1'b0);
        #1;
        check("R3 held until edge", outs(), 5'b000_0_0);
        @(negedge clk);
        check("R3 after one edge", outs(), 5'b110_1_1);

        // R4: disabled top window yields to the next one
        win_en = 3'b110;
        drive(4'd3, 5'd9, 1'b0, 3'd0, 1'b0);
        @(negedge clk);
        check("R4 disabled window", outs(), 5'b010_1_1);

        // R5: inverted row range on w1 removes it
        win_row_lo[7:4] = 4'd6;
        win_row_hi[7:4] = 4'd3;
        drive(4'd4, 5'd9, 1'b0, 3'd0, 1'b0);
        @(negedge clk);
        check("R5 inverted rows", outs(), 5'b000_0_0);

        // R5: inverted column range on w2 removes it
        win_col_lo[14:10] = 5'd20;
        win_col_hi[14:10] = 5'd12;
        drive(4'd7, 5'd16, 1'b0, 3'd0, 1'b0);
        @(negedge clk);
        check("R5 inverted cols", outs(), 5'b000_0_0);

        // R10: mode flip leaves colour and half-tone on a window cell
        base_windows();
        drive(4'd7, 5'd16, 1'b0, 3'd0, 1'b1);
        @(negedge clk);
        check("R10 mode 1 window cell", outs(), 5'b110_0_1);

        // R1: asynchronous reset clears outputs at once
        rst_n = 1'b0;
        #1;
        check("R1 async reset", outs(), 5'b000_0_0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule